// File: doc/BRIEF.md
# Multi-Cycle Signed/Unsigned Integer Divider

This block computes the quotient of two 32-bit integers over many clock cycles, as the divide unit beside an integer pipeline. A caller presents a dividend, a divisor and a mode bit that picks two's-complement or unsigned interpretation, then pulses `start`. The block takes the operands on that edge, raises `busy` while it works, and marks completion with a single-cycle `done` pulse. The quotient stays on `quotient` until the next operation completes.

Inside, the core works on magnitudes with a restoring shift-subtract loop that yields one quotient bit per cycle. A final correction step restores the sign. Two cases that other designs trap on get fixed results here. A zero divisor returns zero at once. The most-negative value divided by minus one returns the most-negative value.

The controller has three states. IDLE waits for `start`. CALC runs the 32 shift-subtract steps. FIX applies the sign and raises `done`. The transitions are: IDLE->CALC (start with a non-zero divisor); IDLE->IDLE (start with a zero divisor, which pulses `done` with a zero quotient; also no start); CALC->CALC (step counter below 31); CALC->FIX (32nd step taken); FIX->IDLE (always).

Top module: `int_divider`

## Requirements
- R1: After synchronous active-high reset, including a reset applied in the middle of an operation, `busy` is 0, `done` is 0 and `quotient` is 0.
- R2: With `is_signed`=0 the quotient is floor(dividend/divisor), both read as unsigned 32-bit numbers.
- R3: With `is_signed`=1 the quotient is the two's-complement quotient rounded toward zero. It is negative when exactly one operand is negative.
- R4: A zero divisor in either mode gives a quotient of 0. `done` is high in the cycle right after the accepting edge, and `busy` never rises.
- R5: With `is_signed`=1, dividend 0x80000000 divided by 0xFFFFFFFF gives 0x80000000.
- R6: With a non-zero divisor, `busy` is high from the cycle after the accepting edge. `done` rises exactly 33 cycles after that edge, in the same cycle that `busy` falls. `busy` and `done` are never high together.
- R7: `done` is high for exactly one cycle per completed operation.
- R8: `start` is ignored while `busy` is high. The operands presented with it change neither the result nor the completion time of the running operation.
- R9: `quotient` changes only in a cycle where `done` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted when not busy |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 32 | Numerator, sampled on the accepting edge |
| divisor | input | 32 | Denominator, sampled on the accepting edge |
| quotient | output | 32 | Result, valid from the `done` cycle onward |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives in the middle of the 32 iterations. If the design took it, the bug would show only as a changed quotient or a shifted completion cycle. The stimulus starts a known division, waits several cycles into CALC, and drives `start` with operands that give a very different quotient. It then checks that `done` still lands on cycle 33 with the first result. The sign paths are reached through vectors that mix operand signs and through the most-negative dividend with divisors of 1, 2 and -1. A reset in the middle of an operation is also driven.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, result sign and zero-divisor detection.
module div_prep #(
    parameter int WIDTH = 32
) (
    input  logic             is_signed,
    input  logic [WIDTH-1:0] num_in,
    input  logic [WIDTH-1:0] den_in,
    output logic [WIDTH-1:0] num_mag,
    output logic [WIDTH-1:0] den_mag,
    output logic             neg_result,
    output logic             den_is_zero
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg     = is_signed & num_in[WIDTH-1];
        den_neg     = is_signed & den_in[WIDTH-1];
        // Negating the most-negative value yields itself, which is the
        // correct unsigned magnitude.
        num_mag     = num_neg ? (~num_in + 1'b1) : num_in;
        den_mag     = den_neg ? (~den_in + 1'b1) : den_in;
        neg_result  = num_neg ^ den_neg;
        den_is_zero = (den_in == '0);
    end

endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration.
module div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] part_in,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] den,
    output logic [WIDTH-1:0] part_out,
    output logic [WIDTH-1:0] acc_out
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] shifted;
    logic [EXT-1:0] trial;
    logic           fits;

    always_comb begin
        shifted  = {part_in, acc_in[WIDTH-1]};
        trial    = shifted - {1'b0, den};
        fits     = ~trial[EXT-1];
        part_out = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        acc_out  = {acc_in[WIDTH-2:0], fits};
    end

endmodule

// File: rtl/div_ctrl.sv
// Sequencer: IDLE -> CALC (WIDTH steps) -> FIX -> IDLE.
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic den_zero,
    output logic load,
    output logic zero_hit,
    output logic step_en,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    div_state_e       state_q;
    div_state_e       state_d;
    logic [CNT_W-1:0] step_q;

    // State register and step counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= (state_q == ST_CALC) ? step_q + 1'b1 : '0;
        end
    end

    // Transition logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && !den_zero) state_d = ST_CALC;
            ST_CALC: if (step_q == LAST)     state_d = ST_FIX;
            ST_FIX:                          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        load     = 1'b0;
        zero_hit = 1'b0;
        step_en  = 1'b0;
        finish   = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                load     = start & ~den_zero;
                zero_hit = start & den_zero;
            end
            ST_CALC: step_en = 1'b1;
            ST_FIX:  finish  = 1'b1;
            default: busy    = 1'b0;
        endcase
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= zero_hit | finish;
    end

endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic             busy,
    output logic             done
);
    logic [WIDTH-1:0] num_mag, den_mag;
    logic             neg_result, den_is_zero;
    logic             load, zero_hit, step_en, finish;

    logic [WIDTH-1:0] part_q, acc_q, den_q;
    logic             neg_q;
    logic [WIDTH-1:0] part_nx, acc_nx;
    logic [WIDTH-1:0] quot_q;

    div_prep #(.WIDTH(WIDTH)) u_prep (
        .is_signed  (is_signed),
        .num_in     (dividend),
        .den_in     (divisor),
        .num_mag    (num_mag),
        .den_mag    (den_mag),
        .neg_result (neg_result),
        .den_is_zero(den_is_zero)
    );

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .den_zero(den_is_zero),
        .load    (load),
        .zero_hit(zero_hit),
        .step_en (step_en),
        .finish  (finish),
        .busy    (busy),
        .done    (done)
    );

    div_step #(.WIDTH(WIDTH)) u_step (
        .part_in (part_q),
        .acc_in  (acc_q),
        .den     (den_q),
        .part_out(part_nx),
        .acc_out (acc_nx)
    );

    // Iteration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            acc_q  <= '0;
            den_q  <= '0;
            neg_q  <= 1'b0;
        end else if (load) begin
            part_q <= '0;
            acc_q  <= num_mag;
            den_q  <= den_mag;
            neg_q  <= neg_result;
        end else if (step_en) begin
            part_q <= part_nx;
            acc_q  <= acc_nx;
        end
    end

    // Result register with sign correction.
    always_ff @(posedge clk) begin
        if (rst || zero_hit) quot_q <= '0;
        else if (finish)     quot_q <= neg_q ? (~acc_q + 1'b1) : acc_q;
    end

    assign quotient = quot_q;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] divisor,
    input logic [WIDTH-1:0] quotient,
    input logic             busy,
    input logic             done
);
    localparam int LAT_W = $clog2(WIDTH + 3) + 1;
    localparam logic [LAT_W-1:0] LAT_EXP = LAT_W'(WIDTH + 2);

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)                 lat_q <= '0;
        else if (start && !busy) lat_q <= LAT_W'(1);
        else if (busy)           lat_q <= lat_q + 1'b1;
    end

    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && lat_q == LAT_EXP));

    p_enter_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor != '0) |=> busy);

    p_zero_div_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=> (done && !busy && quotient == '0));

    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient));

endmodule

bind int_divider div_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .divisor (divisor),
    .quotient(quotient),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_int_divider.sv
`timescale 1ns/1ps
module sim_int_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [31:0] quotient;
    logic        busy, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    int_divider u0 (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .busy(busy), .done(done)
    );

    // {signed, dividend, divisor, expected quotient}
    localparam int NV = 15;
    localparam logic [96:0] VEC [NV] = '{
        {1'b0, 32'd100,        32'd7,          32'd14},
        {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1},
        {1'b0, 32'd5,          32'd9,          32'd0},
        {1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0},
        {1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC},
        {1'b0, 32'h075BCD15,   32'h000003E8,   32'h0001E240},
        {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
        {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
        {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3},
        {1'b1, 32'h80000000,   32'd1,          32'h80000000},
        {1'b1, 32'h80000000,   32'd2,          32'hC0000000},
        {1'b1, 32'h7FFFFFFF,   32'h80000000,   32'd0},
        {1'b1, 32'd1000,       32'd0,          32'd0},
        {1'b0, 32'hDEADBEEF,   32'd0,          32'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Launch one operation and wait for done; returns latency in edges.
    task automatic launch(input logic sg, input logic [31:0] a, input logic [31:0] b,
                          output int lat);
        @(negedge clk);
        start = 1'b1; is_signed = sg; dividend = a; divisor = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; dividend = 32'h5A5A5A5A; divisor = 32'h3;
        lat = 0;
        while (!done && lat < 60) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic sg, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_q, input string req);
        int lat;
        launch(sg, a, b, lat);
        check(req, "quotient", quotient, exp_q);
        if (b == 0) check("R4", "zero-divisor latency", lat, 0);
        else        check("R6", "latency", lat, 33);
        check("R6", "busy low at done", {31'd0, busy}, 0);
        @(negedge clk);
        check("R7", "done pulse width", {31'd0, done}, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog: actual=%0d expected<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check("R1", "busy after reset", {31'd0, busy}, 0);
        check("R1", "done after reset", {31'd0, done}, 0);
        check("R1", "quotient after reset", quotient, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string req;
            if (VEC[i][31:0+32] == 0)  req = "R4";
            else if (VEC[i][96])       req = "R3";
            else                       req = "R2";
            run_op(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], req);
        end

        // R5: most-negative over minus one, signed
        run_op(1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, "R5");

        // R6: busy visible right after an accepted start
        @(negedge clk);
        start = 1'b1; is_signed = 1'b0; dividend = 32'd50; divisor = 32'd5;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R6", "busy after accept", {31'd0, busy}, 1);
        while (!done) @(negedge clk);
        check("R2", "50/5", quotient, 10);

        // R8: start while busy is ignored
        @(negedge clk);
        start = 1'b1; is_signed = 1'b0; dividend = 32'd100; divisor = 32'd7;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
        start = 1'b1; dividend = 32'd999; divisor = 32'd1; is_signed = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 60) begin @(posedge clk); @(negedge clk); lat++; end
        check("R8", "quotient with ignored start", quotient, 14);
        check("R8", "latency with ignored start", lat, 33);

        // R9: quotient holds while idle with changing inputs
        repeat (6) begin
            @(negedge clk);
            dividend = dividend + 32'd77; divisor = divisor + 32'd3;
        end
        check("R9", "quotient held", quotient, 14);

        // R1: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; is_signed = 1'b0; dividend = 32'd1000; divisor = 32'd3;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "busy after mid reset", {31'd0, busy}, 0);
        check("R1", "done after mid reset", {31'd0, done}, 0);
        check("R1", "quotient after mid reset", quotient, 0);
        rst = 1'b0;

        // Post-reset operation still correct
        run_op(1'b1, 32'hFFFFFF9C, 32'd7, 32'hFFFFFFF2, "R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule